// File: doc/BRIEF.md
# Key Code Debounce Filter

This block cleans up the code word produced by a keypad scanner before anything downstream acts on it. The scanner's output flickers while a key's contacts settle, and it can also show stray values while the scan moves between rows. The filter samples the whole code word on every rising edge of a slow sampling clock, nominally about 1 kHz. It pushes each sample into a chain of delay taps and compares every tap with its neighbour. Only when all of those equality tests pass at once does it pass the newest code to its output.

When any neighbour pair differs, the output keeps the last accepted code. A single-cycle strobe marks each clock in which the output takes a value different from the one it held before. This lets a consumer react once per settled key change without comparing codes itself. The code width and the number of taps are parameters. The code word is handled as opaque data, so sentinel values such as a "no key" marker are debounced like any key number.

Top module: `key_code_debounce`

## Requirements
- R1: While rst_n is low, code_out and code_new are 0 at once, without waiting for a clock, and every delay tap holds 0. As a result, holding code_in at 0 after reset never raises code_new.
- R2: code_in is sampled on every rising edge of clk_smp and shifts through TAPS delay taps, one tap per edge. TAPS defaults to 4 and must be at least 2. CODE_W defaults to 4 and must be at least 1.
- R3: If code_in holds the same value V at TAPS consecutive rising edges, code_out equals V after the next rising edge. That is TAPS edges after the first edge that sampled V.
- R4: If the last TAPS samples are not all equal, code_out keeps its previous value. In particular, a value held for fewer than TAPS samples never reaches code_out.
- R5: code_new is high for exactly the clock cycles in which code_out has just changed to a value different from the one it held in the previous cycle. A settled code equal to the present output gives no pulse.
- R6: Every one of the 2^CODE_W code values is filtered the same way. This includes all-ones and sentinel values outside the key range, such as 17 with CODE_W = 5.
- R7: A glitch inside a run restarts qualification. After a differing sample, the original value needs TAPS fresh equal samples before it can be accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_smp | input | 1 | Slow sampling clock (about 1 kHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_in | input | CODE_W | Raw code word from the scanner |
| code_out | output | CODE_W | Debounced code word |
| code_new | output | 1 | One-cycle pulse when code_out changes value |

## Verification
A corrupted tap or a broken comparison shows up at code_out as a code that arrives one or more edges early or late, or that leaks through from a short glitch. Either error is visible at the first edge where the run length and the acceptance edge disagree. A wrong hold register or strobe condition shows up in the same cycle as a code_new pulse without a change of value, or as a change with no pulse. The bench sweeps every code value of a 5-bit configuration and every glitch length below the tap count. It compares the ports against an arithmetic run-length model after every edge, so any such error is caught within TAPS+1 cycles of the stimulus that exposes it.

// File: rtl/key_dbnc_pkg.sv
package key_dbnc_pkg;
   localparam int unsigned MIN_TAPS   = 2;
   localparam int unsigned MIN_CODE_W = 1;

   function automatic bit taps_ok(input int unsigned taps, input int unsigned w);
      return (taps >= MIN_TAPS) && (w >= MIN_CODE_W);
   endfunction
endpackage

// File: rtl/key_dbnc_tapline.sv
module key_dbnc_tapline #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned TAPS   = 4
) (
   input  logic                          clk_smp,
   input  logic                          rst_n,
   input  logic [CODE_W-1:0]             din,
   output logic [TAPS-1:0][CODE_W-1:0]   taps
);
   // tap 0 holds the newest sample, tap TAPS-1 the oldest
   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) taps[0] <= '0;
      else        taps[0] <= din;
   end

   for (genvar i = 1; i < TAPS; i++) begin : g_tap
      always_ff @(posedge clk_smp or negedge rst_n) begin
         if (!rst_n) taps[i] <= '0;
         else        taps[i] <= taps[i-1];
      end
   end
endmodule

// File: rtl/key_dbnc_match.sv
module key_dbnc_match #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned TAPS   = 4
) (
   input  logic [TAPS-1:0][CODE_W-1:0] taps,
   output logic                        agree
);
   localparam int unsigned PAIRS = TAPS - 1;

   logic [PAIRS-1:0] pair_eq;

   for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign pair_eq[p] = (taps[p] == taps[p+1]);
   end

   if (PAIRS == 1) begin : g_single
      assign agree = pair_eq[0];
   end else begin : g_reduce
      assign agree = &pair_eq;
   end
endmodule

// File: rtl/key_dbnc_hold.sv
module key_dbnc_hold #(
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk_smp,
   input  logic              rst_n,
   input  logic              agree,
   input  logic [CODE_W-1:0] newest,
   output logic [CODE_W-1:0] code_q,
   output logic              fresh
);
   logic differs;
   assign differs = (newest != code_q);

   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         fresh  <= 1'b0;
      end else begin
         fresh <= agree && differs;
         if (agree) code_q <= newest;
      end
   end

   // R5: a pulse always comes with a changed value
   assert_pulse_means_change_R5: assert property (@(posedge clk_smp) disable iff (!rst_n)
      fresh |-> (code_q != $past(code_q)))
      else $error("strobe without a change of code");

   // R5: a changed value always comes with a pulse
   assert_change_means_pulse_R5: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (code_q != $past(code_q)) |-> fresh)
      else $error("code changed without strobe");
endmodule

// File: rtl/key_code_debounce.sv
module key_code_debounce #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned TAPS   = 4
) (
   input  logic              clk_smp,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out,
   output logic              code_new
);
   import key_dbnc_pkg::*;

   initial begin
      assert_param_range_R2: assert (taps_ok(TAPS, CODE_W))
         else $error("TAPS must be >= 2 and CODE_W >= 1");
   end

   logic [TAPS-1:0][CODE_W-1:0] taps;
   logic                        agree;

   key_dbnc_tapline #(.CODE_W(CODE_W), .TAPS(TAPS)) i_tapline (
      .clk_smp (clk_smp),
      .rst_n   (rst_n),
      .din     (code_in),
      .taps    (taps)
   );

   key_dbnc_match #(.CODE_W(CODE_W), .TAPS(TAPS)) i_match (
      .taps  (taps),
      .agree (agree)
   );

   key_dbnc_hold #(.CODE_W(CODE_W)) i_hold (
      .clk_smp (clk_smp),
      .rst_n   (rst_n),
      .agree   (agree),
      .newest  (taps[0]),
      .code_q  (code_out),
      .fresh   (code_new)
   );

   // R4: without agreement the output holds
   assert_hold_on_disagree_R4: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !agree |=> $stable(code_out))
      else $error("output moved without agreement");

   // R3: with agreement the output takes the newest tap
   assert_accept_on_agree_R3: assert property (@(posedge clk_smp) disable iff (!rst_n)
      agree |=> (code_out == $past(taps[0])))
      else $error("agreed code not accepted");
endmodule

// File: tb/test_key_code_debounce.sv
module test_key_code_debounce;
   localparam int unsigned W = 5;
   localparam int unsigned S = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] code_in = '0;
   logic [W-1:0] code_out;
   logic         code_new;

   int checks = 0;
   int errors = 0;

   // arithmetic model: last sample, length of its run, expected outputs
   logic [W-1:0] m_last = '0;
   int           m_run  = S;
   logic [W-1:0] m_out  = '0;
   logic         m_new  = 1'b0;

   always #2.5 clk = ~clk;

   key_code_debounce #(.CODE_W(W), .TAPS(S)) i_key_code_debounce (
      .clk_smp  (clk),
      .rst_n    (rst_n),
      .code_in  (code_in),
      .code_out (code_out),
      .code_new (code_new)
   );

   task automatic check(input string req, input logic [W-1:0] exp_o, input logic exp_n);
      checks++;
      if (code_out !== exp_o || code_new !== exp_n) begin
         errors++;
         $display("FAIL %s: out=%0d new=%0b expected out=%0d new=%0b at %0t",
                  req, code_out, code_new, exp_o, exp_n, $time);
      end
   endtask

   task automatic model_reset();
      m_last = '0; m_run = S; m_out = '0; m_new = 1'b0;
   endtask

   // called at a negedge; drives v, crosses one rising edge, checks
   task automatic step(input logic [W-1:0] v, input string req);
      code_in = v;
      @(posedge clk);
      #1;
      if (m_run >= S) begin
         m_new = (m_last != m_out);
         m_out = m_last;
      end else begin
         m_new = 1'b0;
      end
      if (v == m_last) begin
         if (m_run < S) m_run++;
      end else begin
         m_run = 1;
      end
      m_last = v;
      check(req, m_out, m_new);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      #1;
      check("R1 async reset", '0, 1'b0);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      // R1: holding zero after reset produces no pulse
      for (int k = 0; k < S + 2; k++) step('0, "R1 zero after reset");

      // R3 R6: every code value, held long enough
      for (int c = 1; c < (1 << W); c++)
         for (int k = 0; k < S + 2; k++) step(W'(c), "R3 R6 code sweep");
      step(W'(0), "R3 back to zero");
      for (int k = 0; k < S + 1; k++) step(W'(0), "R3 back to zero");

      // R4: glitches of every short length never pass
      for (int g = 1; g < S; g++) begin
         for (int v = 1; v < (1 << W); v += 7) begin
            for (int k = 0; k < g; k++) step(W'(v), "R4 short glitch");
            for (int k = 0; k < S + 1; k++) step(W'(0), "R4 after glitch");
         end
      end

      // R6: reserved sentinel 17 debounced like data
      for (int k = 0; k < S + 1; k++) step(W'(17), "R6 sentinel");
      // R5: re-settling on the same value gives no pulse
      step(W'(3), "R5 one-cycle blip");
      for (int k = 0; k < S + 2; k++) step(W'(17), "R5 same code no pulse");

      // R7: glitch inside a run restarts qualification
      for (int k = 0; k < S - 1; k++) step(W'(9), "R7 partial run");
      step(W'(17), "R7 interrupt");
      for (int k = 0; k < S + 1; k++) step(W'(9), "R7 fresh run");
      // alternating values never settle
      for (int k = 0; k < 4 * S; k++) step((k % 2) ? W'(21) : W'(10), "R4 alternating");
      for (int k = 0; k < S + 1; k++) step(W'(31), "R6 all ones");

      // R2: shift depth, a run of exactly S samples then change
      for (int k = 0; k < S; k++) step(W'(6), "R2 exact run");
      for (int k = 0; k < S + 1; k++) step(W'(12), "R2 next run");

      // R1: asynchronous reset in mid-cycle
      #1;
      rst_n = 1'b0;
      #0.5;
      check("R1 mid-cycle reset", '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      for (int k = 0; k < S + 2; k++) step('0, "R1 taps cleared");
      for (int k = 0; k < S + 1; k++) step(W'(5), "R3 after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule